// File: doc/BRIEF.md
# Dual-Channel DAC Data Hold and Transfer

This block sits between a register bus and the conversion cores of a two-channel digital-to-analog converter. Software writes sample values into a holding register for each channel. It can write to one channel, or it can write both channels at once with a single 32-bit word. A write is aligned in one of three ways: a 12-bit value at the bottom of a half-word, a 12-bit value at the top of a half-word, or an 8-bit byte that becomes the top bits of the 12-bit value. The held value then moves to the channel's output register, which drives the converter.

How each channel moves its held value depends on its trigger-enable input. With the trigger disabled, the held value reaches the output one clock after the write. With the trigger enabled, a rising edge on the trigger line picked by the channel's select field starts a fixed three-clock transfer. During that transfer the channel ignores further triggers. When both channels select the same line, they update in the same cycle. Each output register has a one-cycle update strobe that marks a new value.

Top module: `dac_hold_xfer`

## Requirements
- R1: While `rst_n` is low, both output values are 0 and both update strobes are 0. The held values also reset to 0.
- R2: The format code `wr_fmt` selects the alignment. With code 00 (right-aligned 12-bit) the value is bits 11:0 of the half-word. Code 11 behaves like code 00. In a dual write, channel 0 takes bits 15:0 of `wr_data` and channel 1 takes bits 31:16.
- R3: With code 01 (left-aligned 12-bit) the value is bits 15:4 of the half-word.
- R4: With code 10 (8-bit) the value is bits 7:0 of the half-word placed in bits 11:4, with bits 3:0 cleared.
- R5: A single-channel write (`wr_ch[n]`) loads only channel n, taking bits 15:0 of `wr_data`. The other channel's held and output values are left unchanged.
- R6: With `trig_en[n]` low, a write captured at clock edge k puts the new value on channel n's output at edge k+1. The update strobe goes high for that one cycle.
- R7: With `trig_en[n]` high, a write does not transfer. A rising edge on the selected line, sampled at edge t, loads the value held at edge t+3 into the output at edge t+3.
- R8: A rising edge that arrives while channel n's three-cycle transfer is pending is ignored. It produces no further update.
- R9: Triggers are edge-sensitive. A line held high produces only one transfer, and an edge on a line that is not selected produces none.
- R10: Channels with trigger enabled and equal select values, triggered by one edge, update both outputs in the same cycle.
- R11: An output value changes only in a cycle in which its update strobe is high. Each strobe is high for exactly one cycle per transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_ch | input | 2 | Per-channel write strobes (bit n writes channel n from bits 15:0) |
| wr_dual | input | 1 | Dual write strobe, loads both channels from one word |
| wr_fmt | input | 2 | Alignment code: 00 right 12-bit, 01 left 12-bit, 10 8-bit, 11 as 00 |
| wr_data | input | 32 | Write data |
| trig_en | input | 2 | Per-channel trigger enable |
| trig_sel0 | input | clog2(NTRIG) | Trigger line select, channel 0 |
| trig_sel1 | input | clog2(NTRIG) | Trigger line select, channel 1 |
| trig_in | input | NTRIG | Trigger lines |
| out0 | output | DW | Output register, channel 0 |
| out1 | output | DW | Output register, channel 1 |
| upd | output | 2 | Per-channel one-cycle update strobe |

## Verification
The checker enforces the following on every cycle:
- the reset values;
- that an output moves only together with its strobe;
- that an untriggered write always leads to a strobe two edges later;
- that every strobe traces back to either such a write or an accepted trigger four edges earlier;
- that no two accepted triggers fall within three cycles of each other.

Some behaviours are shown only by the bench scenarios:
- the exact values under each alignment code;
- the independence of the channels on a single write;
- that the latest held value is the one transferred;
- that a high level does not re-trigger;
- the simultaneous update under a shared select.

// File: rtl/dhx_pkg.sv
`timescale 1ns/1ps
// dhx_pkg: shared types for the DAC hold-and-transfer block.
// Assumes: format codes are fixed by the register bus decode.
package dhx_pkg;
    typedef enum logic [1:0] {
        FMT_R12 = 2'b00,
        FMT_L12 = 2'b01,
        FMT_R8  = 2'b10,
        FMT_RSV = 2'b11
    } fmt_e;

    // Clock edges from accepted trigger to output load, counting the accepting edge.
    localparam int XFER_CYC = 3;
endpackage

// File: rtl/dhx_align.sv
`timescale 1ns/1ps
// dhx_align: turns one half-word of write data into a DW-bit sample
// according to the alignment code. Purely combinational.
// Assumes: HW >= DW >= 8.
module dhx_align #(
    parameter int DW = 12,
    parameter int HW = 16
) (
    input  logic [1:0]    fmt,
    input  logic [HW-1:0] half,
    output logic [DW-1:0] val
);
    import dhx_pkg::*;

    localparam int PAD = DW - 8;

    // Pick the bit field that the alignment code designates.
    always_comb begin
        unique case (fmt_e'(fmt))
            FMT_L12: val = half[HW-1 -: DW];
            FMT_R8:  val = {half[7:0], {PAD{1'b0}}};
            default: val = half[DW-1:0];
        endcase
    end
endmodule

// File: rtl/dhx_trig_sel.sv
`timescale 1ns/1ps
// dhx_trig_sel: selects one of NTRIG trigger lines and flags its rising edge.
// Assumes: lines are synchronous to clk. The history bit resets high, so a
// line already high when reset releases is not taken as an edge.
module dhx_trig_sel #(
    parameter int NTRIG = 8,
    parameter int SELW  = $clog2(NTRIG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTRIG-1:0] lines,
    input  logic [SELW-1:0]  sel,
    output logic             rise
);
    logic cur;
    logic prev;

    assign cur  = lines[sel];
    assign rise = cur & ~prev;

    // Remember the selected line's level from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= cur;
    end
endmodule

// File: rtl/dhx_chan.sv
`timescale 1ns/1ps
// dhx_chan: one channel's holding register, output register and transfer timing.
// The software path transfers one edge after the write. The trigger path
// transfers XFER_CYC edges after an accepted rising edge and ignores edges
// while a transfer is pending.
// Assumes: wdata is already aligned by dhx_align.
module dhx_chan #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          trig_en,
    input  logic          rise,
    output logic [DW-1:0] dout,
    output logic          upd,
    output logic          sw_go,
    output logic          hit
);
    import dhx_pkg::*;

    localparam int CW = $clog2(XFER_CYC);

    logic [DW-1:0] hold;
    logic          sw_pend;
    logic          tr_pend;
    logic [CW-1:0] cnt;
    logic          xfer_now;

    assign sw_go    = wr & ~trig_en;
    assign hit      = rise & trig_en & ~tr_pend;
    assign xfer_now = sw_pend | (tr_pend & (cnt == '0));

    // Capture written data into the holding register.
    always_ff @(posedge clk) begin
        if (!rst_n)  hold <= '0;
        else if (wr) hold <= wdata;
    end

    // Mark a software-start transfer for the next edge.
    always_ff @(posedge clk) begin
        if (!rst_n) sw_pend <= 1'b0;
        else        sw_pend <= sw_go;
    end

    // Count down the trigger-to-output delay. New edges are blocked while pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tr_pend <= 1'b0;
            cnt     <= '0;
        end else if (hit) begin
            tr_pend <= 1'b1;
            cnt     <= CW'(XFER_CYC - 1);
        end else if (tr_pend) begin
            if (cnt == '0) tr_pend <= 1'b0;
            else           cnt     <= cnt - 1'b1;
        end
    end

    // Load the output register and pulse the strobe on a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
            upd  <= 1'b0;
        end else begin
            upd <= xfer_now;
            if (xfer_now) dout <= hold;
        end
    end
endmodule

// File: rtl/dac_hold_xfer.sv
`timescale 1ns/1ps
// dac_hold_xfer: two-channel holding and output-transfer logic for a DAC.
// It decodes single and dual writes, aligns the data, selects and
// edge-detects each channel's trigger, and schedules output loads.
// Assumes: synchronous inputs. A dual write has priority over a single
// write for channel 1's data source.
module dac_hold_xfer #(
    parameter int NTRIG = 8,
    parameter int DW    = 12,
    parameter int WW    = 32,
    parameter int SELW  = $clog2(NTRIG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       wr_ch,
    input  logic             wr_dual,
    input  logic [1:0]       wr_fmt,
    input  logic [WW-1:0]    wr_data,
    input  logic [1:0]       trig_en,
    input  logic [SELW-1:0]  trig_sel0,
    input  logic [SELW-1:0]  trig_sel1,
    input  logic [NTRIG-1:0] trig_in,
    output logic [DW-1:0]    out0,
    output logic [DW-1:0]    out1,
    output logic [1:0]       upd
);
    localparam int NCH = 2;
    localparam int HW  = WW / 2;

    logic [HW-1:0]   half_src [NCH];
    logic [SELW-1:0] sel_arr  [NCH];
    logic [DW-1:0]   dout_arr [NCH];
    logic [NCH-1:0]  wr_any;
    logic [NCH-1:0]  sw_go_w;
    logic [NCH-1:0]  hit_w;

    // Route write data halves and strobes to each channel.
    always_comb begin
        half_src[0] = wr_data[HW-1:0];
        half_src[1] = wr_dual ? wr_data[WW-1:HW] : wr_data[HW-1:0];
        wr_any      = wr_ch | {NCH{wr_dual}};
        sel_arr[0]  = trig_sel0;
        sel_arr[1]  = trig_sel1;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [DW-1:0] aligned;
        logic          rise;

        dhx_align #(.DW(DW), .HW(HW)) u_align (
            .fmt  (wr_fmt),
            .half (half_src[g]),
            .val  (aligned)
        );

        dhx_trig_sel #(.NTRIG(NTRIG), .SELW(SELW)) u_trig (
            .clk   (clk),
            .rst_n (rst_n),
            .lines (trig_in),
            .sel   (sel_arr[g]),
            .rise  (rise)
        );

        dhx_chan #(.DW(DW)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      (wr_any[g]),
            .wdata   (aligned),
            .trig_en (trig_en[g]),
            .rise    (rise),
            .dout    (dout_arr[g]),
            .upd     (upd[g]),
            .sw_go   (sw_go_w[g]),
            .hit     (hit_w[g])
        );
    end

    assign out0 = dout_arr[0];
    assign out1 = dout_arr[1];
endmodule

// File: rtl/dhx_check.sv
`timescale 1ns/1ps
// dhx_check: temporal checks on dac_hold_xfer, attached by bind.
module dhx_check #(
    parameter int DW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    upd,
    input logic [DW-1:0] out0,
    input logic [DW-1:0] out1,
    input logic [1:0]    sw_go,
    input logic [1:0]    hit
);
    // R1: reset clears outputs and strobes
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (upd == 2'b00 && out0 == '0 && out1 == '0));

    // R11: outputs move only with their strobe
    a_r11_out0_with_upd: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out0) |-> upd[0]);
    a_r11_out1_with_upd: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out1) |-> upd[1]);

    for (genvar g = 0; g < 2; g++) begin : g_pc
        // R6: an untriggered write strobes two edges later
        a_r6_sw_strobe: assert property (@(posedge clk) disable iff (!rst_n)
            sw_go[g] |-> ##2 upd[g]);
        // R7: every strobe comes from a write or an accepted trigger
        a_r7_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
            upd[g] |-> ($past(sw_go[g], 2) || $past(hit[g], 4)));
        // R8: no trigger accepted while a transfer is pending
        a_r8_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
            hit[g] |-> (!$past(hit[g], 1) && !$past(hit[g], 2) && !$past(hit[g], 3)));
    end
endmodule

bind dac_hold_xfer dhx_check #(.DW(DW)) u_dhx_check (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (upd),
    .out0  (out0),
    .out1  (out1),
    .sw_go (sw_go_w),
    .hit   (hit_w)
);

// File: tb/test_dac_hold_xfer.sv
`timescale 1ns/1ps
module test_dac_hold_xfer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  wr_ch = '0;
    logic        wr_dual = 1'b0;
    logic [1:0]  wr_fmt = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  trig_en = '0;
    logic [2:0]  trig_sel0 = '0;
    logic [2:0]  trig_sel1 = '0;
    logic [7:0]  trig_in = '0;
    logic [11:0] out0, out1;
    logic [1:0]  upd;

    int total = 0;
    int bad = 0;
    logic [11:0] h0 = '0, h1 = '0, e0 = '0, e1 = '0;

    always #2.5 clk = ~clk;

    dac_hold_xfer i_dac_hold_xfer (
        .clk(clk), .rst_n(rst_n), .wr_ch(wr_ch), .wr_dual(wr_dual),
        .wr_fmt(wr_fmt), .wr_data(wr_data), .trig_en(trig_en),
        .trig_sel0(trig_sel0), .trig_sel1(trig_sel1), .trig_in(trig_in),
        .out0(out0), .out1(out1), .upd(upd)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [11:0] expv(input int fmt, input logic [15:0] h);
        int v;
        v = int'(h);
        case (fmt)
            1:       return 12'(v / 16);
            2:       return 12'((v % 256) * 16);
            default: return 12'(v % 4096);
        endcase
    endfunction

    function automatic string fmt_req(input int fmt);
        return (fmt == 1) ? "R3" : (fmt == 2) ? "R4" : "R2";
    endfunction

    // Drive one write for a cycle and update the bench's model of the held values.
    task automatic do_write(input logic [1:0] m, input logic d, input int fmt,
                            input logic [31:0] data);
        @(negedge clk);
        wr_ch = m; wr_dual = d; wr_fmt = 2'(fmt); wr_data = data;
        if (d || m[0]) h0 = expv(fmt, data[15:0]);
        if (d || m[1]) h1 = expv(fmt, d ? data[31:16] : data[15:0]);
        @(negedge clk);
        wr_ch = '0; wr_dual = 1'b0;
    endtask

    // Raise a line and check the three-edge delay to the update.
    task automatic pulse_check(input int line, input logic [1:0] mask, input string req);
        @(negedge clk);
        trig_in[line] = 1'b1;
        for (int i = 1; i <= 3; i++) begin
            @(negedge clk);
            chk(req, "no upd before third edge", 32'(upd), 32'(0));
        end
        @(negedge clk);
        chk(req, "upd at third edge", 32'(upd), 32'(mask));
        if (mask[0]) begin e0 = h0; chk(req, "out0 after trigger", 32'(out0), 32'(e0)); end
        if (mask[1]) begin e1 = h1; chk(req, "out1 after trigger", 32'(out1), 32'(e1)); end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "out0 in reset", 32'(out0), 0);
        chk("R1", "out1 in reset", 32'(out1), 0);
        chk("R1", "upd in reset", 32'(upd), 0);
        rst_n = 1'b1;

        // R2 R3 R4 R6 R11: dual software writes over all codes
        for (int fmt = 0; fmt < 4; fmt++) begin
            for (int k = 0; k < 12; k++) begin
                logic [31:0] d;
                d = 32'h9E3779B9 * 32'(k + 1) + 32'(fmt * 4099);
                do_write(2'b00, 1'b1, fmt, d);
                chk("R6", "no upd on write edge", 32'(upd), 0);
                @(negedge clk);
                e0 = h0; e1 = h1;
                chk("R6", "upd after write", 32'(upd), 32'(3));
                chk(fmt_req(fmt), "dual out0", 32'(out0), 32'(expv(fmt, d[15:0])));
                chk(fmt_req(fmt), "dual out1", 32'(out1), 32'(expv(fmt, d[31:16])));
                @(negedge clk);
                chk("R11", "strobe one cycle", 32'(upd), 0);
                chk("R11", "out0 held", 32'(out0), 32'(e0));
            end
        end

        // R5: single-channel writes leave the other channel alone
        for (int ch = 0; ch < 2; ch++) begin
            for (int fmt = 0; fmt < 3; fmt++) begin
                for (int k = 0; k < 4; k++) begin
                    logic [31:0] d;
                    d = 32'h7F4A7C15 * 32'(k + 3 * fmt + 7 * ch + 1);
                    do_write(2'(1 << ch), 1'b0, fmt, d);
                    @(negedge clk);
                    chk("R5", "single upd mask", 32'(upd), 32'(1 << ch));
                    if (ch == 0) begin
                        chk("R5", "written out0", 32'(out0), 32'(expv(fmt, d[15:0])));
                        chk("R5", "untouched out1", 32'(out1), 32'(e1));
                        e0 = h0;
                    end else begin
                        chk("R5", "written out1", 32'(out1), 32'(expv(fmt, d[15:0])));
                        chk("R5", "untouched out0", 32'(out0), 32'(e0));
                        e1 = h1;
                    end
                end
            end
        end

        // R6 R7: mixed enables, channel 1 software, channel 0 triggered
        trig_en = 2'b01;
        do_write(2'b00, 1'b1, 0, 32'h0ABC_0123);
        @(negedge clk);
        e1 = h1;
        chk("R6", "mixed upd only ch1", 32'(upd), 32'(2));
        chk("R7", "ch0 not moved by write", 32'(out0), 32'(e0));
        chk("R6", "ch1 value", 32'(out1), 32'h0ABC);

        // R7 R9: sweep every line on each channel
        trig_en = 2'b11;
        for (int ch = 0; ch < 2; ch++) begin
            for (int line = 0; line < 8; line++) begin
                if (ch == 0) begin trig_sel0 = 3'(line); trig_sel1 = 3'((line + 4) % 8); end
                else         begin trig_sel1 = 3'(line); trig_sel0 = 3'((line + 4) % 8); end
                do_write(2'(1 << ch), 1'b0, 0, 32'(line * 257 + ch * 1000 + 5));
                chk("R7", "write alone no upd", 32'(upd), 0);
                pulse_check(line, 2'(1 << ch), "R7");
                for (int i = 0; i < 6; i++) begin
                    @(negedge clk);
                    chk("R9", "held level no retrigger", 32'(upd), 0);
                end
                trig_in = '0;
                @(negedge clk);
            end
        end

        // R9: edge on an unselected line does nothing
        trig_sel0 = 3'd1; trig_sel1 = 3'd2;
        @(negedge clk);
        trig_in = 8'b1111_1001;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R9", "unselected lines", 32'(upd), 0);
        end
        trig_in = '0;

        // R8 R7: second edge during pending ignored; latest held value transferred
        trig_sel0 = 3'd3;
        do_write(2'b01, 1'b0, 0, 32'h0000_0AAA);
        @(negedge clk);
        trig_in[3] = 1'b1;
        @(negedge clk);
        trig_in[3] = 1'b0;
        wr_ch = 2'b01; wr_fmt = 2'd0; wr_data = 32'h0000_0555; h0 = 12'h555;
        chk("R8", "pending no upd", 32'(upd), 0);
        @(negedge clk);
        wr_ch = '0;
        trig_in[3] = 1'b1;
        chk("R8", "pending no upd", 32'(upd), 0);
        @(negedge clk);
        chk("R8", "pending no upd", 32'(upd), 0);
        @(negedge clk);
        chk("R7", "upd after delay", 32'(upd), 32'(1));
        chk("R7", "latest held value", 32'(out0), 32'h555);
        e0 = 12'h555;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R8", "edge during pending ignored", 32'(upd), 0);
        end
        trig_in = '0;

        // R10: shared select updates both together
        trig_sel0 = 3'd6; trig_sel1 = 3'd6;
        do_write(2'b00, 1'b1, 1, 32'hBEEF_1234);
        chk("R10", "dual write no upd", 32'(upd), 0);
        pulse_check(6, 2'b11, "R10");
        trig_in = '0;
        @(negedge clk);
        chk("R11", "strobe drops", 32'(upd), 0);

        finish_run();
    end
endmodule